// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block carries out the two halves of an indivisible read-modify-write in a multiprocessor system. A load-locked request reads one word from memory, returns it with condition codes, and opens a reservation on that word. A later store-conditional request writes its data only if the reservation is still open for the same word. The store's outcome is reported in the V flag: clear on success, set on failure. Software loops back to the load-locked request when the store fails.

While a reservation is open, the block watches a snoop input. Other CPUs report every memory reference they make on this input. Any reference to the reserved word, whether a read or a write, closes the reservation. Every store-conditional closes the reservation, whether it succeeds or fails. A new load-locked request replaces the old reservation. Requests carry a 4-bit sub-opcode, and only the two codes listed below are acted upon.

Memory is a word-wide port with a one-cycle read latency. Both kinds of request return a result exactly two clock edges after they are issued, so back-to-back requests pipeline cleanly.

Top module: `llsc_monitor`

## Requirements
- R1: Only op_code 4'b1001 (load-locked) and 4'b1000 (store-conditional) act, and only while op_valid is high. Any other code, or op_valid low, produces no memory request and no result, and leaves the reservation as it was.
- R2: A load-locked request raises mem_req with mem_we low in its issue cycle, at the word-aligned address (op_addr with its two low bits forced to zero). Two clock edges after issue, res_valid pulses for one cycle and res_data carries the word that memory returned one cycle after the request.
- R3: The flags of a load-locked result are res_cc = {N,Z,V,C} in bits 3..0. N is bit 31 of the word, Z is set when the word is zero, V is 0, and C is set when any of the four bytes is zero.
- R4: A load-locked request records its word address and opens the reservation. A later load-locked request replaces that address, so a store-conditional to the earlier word fails.
- R5: A store-conditional succeeds when the reservation is open, its word address equals the recorded one, and no matching snoop arrives in the same cycle. On success, mem_req and mem_we are high in the issue cycle with op_data at the aligned address, and res_cc two edges later is 4'b0000.
- R6: A failed store-conditional makes no memory write, and its res_cc two edges later is 4'b0010: only V is set, and N, Z and C are clear.
- R7: Every store-conditional closes the reservation, so a second store-conditional without a new load-locked request fails.
- R8: A valid snoop reference whose word address matches the reserved word closes the reservation. This holds for any byte within that word. A snoop to a different word leaves the reservation open.
- R9: A matching snoop in the same cycle as a store-conditional takes precedence, and the store fails.
- R10: A snoop to the same word in the same cycle as a load-locked request leaves no reservation open.
- R11: Reset closes the reservation and clears res_valid. A store-conditional issued before any load-locked request fails.
- R12: After a failed store-conditional, a new load-locked request followed by a store-conditional with no intervening snoop succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A request is presented this cycle |
| op_code | input | 4 | Sub-opcode: 1001 load-locked, 1000 store-conditional |
| op_addr | input | ADDR_W | Byte address taken from the index register |
| op_data | input | DATA_W | Data for a store-conditional |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| snoop_valid | input | 1 | Another CPU references memory this cycle |
| snoop_addr | input | ADDR_W | Address of that reference |
| res_valid | output | 1 | Result pulse |
| res_data | output | DATA_W | Loaded word (zero for a store-conditional) |
| res_cc | output | 4 | Condition codes {N,Z,V,C} |

## Verification
The memory request and write strobe are combinational, so they are due in the issue cycle itself. The bench samples them one time unit after driving the request, before the next clock edge. The result and flags of either request are due after exactly two rising edges. The bench drives on a falling edge, withdraws the request on the next falling edge, and samples on the falling edge after that. Snoop events are pulsed for one full cycle between requests, or driven together with a request when same-cycle precedence is under test. Memory contents are read from the bench's own memory model after each store.

// File: rtl/llsc_pkg.sv
// Package: shared types and sub-opcode codes for the reservation monitor.
// Assumes the 4-bit sub-opcode field of the short memory reference group.
package llsc_pkg;

    localparam logic [3:0] SUBOP_LL = 4'b1001;
    localparam logic [3:0] SUBOP_SC = 4'b1000;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_LL   = 2'd1,
        KIND_SC   = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/llsc_decode.sv
// Module: llsc_decode
// Turns a request into an operation kind. Codes other than the two acted
// upon, or an idle request, map to KIND_NONE. Purely combinational.
module llsc_decode
    import llsc_pkg::*;
(
    input  logic       op_valid,
    input  logic [3:0] op_code,
    output op_kind_e   kind
);

    // Map the sub-opcode to a kind when a request is present.
    always_comb begin
        kind = KIND_NONE;
        if (op_valid) begin
            case (op_code)
                SUBOP_LL: kind = KIND_LL;
                SUBOP_SC: kind = KIND_SC;
                default:  kind = KIND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/llsc_resv.sv
// Module: llsc_resv
// Holds the lock register and the reservation-valid bit, and compares the
// snoop address against both the lock and the current request.
// Assumes word-granular reservations, where WORD_LSB low address bits
// select a byte within the word. A snoop in the same cycle as a store
// wins over it, and a snoop on the word being locked blocks the new
// reservation.
module llsc_resv #(
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_fire,
    input  logic              sc_fire,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              sc_pass
);

    localparam logic [ADDR_W-1:0] WORD_MASK =
        {{(ADDR_W-WORD_LSB){1'b1}}, {WORD_LSB{1'b0}}};

    logic [ADDR_W-1:0] lock_addr;
    logic              resv_vld;
    logic              snoop_hits_lock;
    logic              snoop_hits_op;
    logic              addr_match;

    // Compare snoop and request word addresses against lock and each other.
    always_comb begin
        snoop_hits_lock = snoop_valid && resv_vld &&
                          ((snoop_addr & WORD_MASK) == lock_addr);
        snoop_hits_op   = snoop_valid &&
                          ((snoop_addr & WORD_MASK) == (op_addr & WORD_MASK));
        addr_match      = ((op_addr & WORD_MASK) == lock_addr);
        sc_pass         = sc_fire && resv_vld && addr_match && !snoop_hits_lock;
    end

    // Open, replace or close the reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_addr <= '0;
            resv_vld  <= 1'b0;
        end else if (ll_fire) begin
            lock_addr <= op_addr & WORD_MASK;
            resv_vld  <= !snoop_hits_op;
        end else if (sc_fire || snoop_hits_lock) begin
            resv_vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_ccgen.sv
// Module: llsc_ccgen
// Computes load flags for a word: sign, zero, V cleared, and C when any
// byte is zero. DATA_W must be a multiple of BYTE_W.
module llsc_ccgen
    import llsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] value,
    output cc_t               cc
);

    localparam int NBYTES = DATA_W / BYTE_W;

    logic [NBYTES-1:0] byte_zero;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Flag a zero byte lane.
        assign byte_zero[b] = (value[b*BYTE_W +: BYTE_W] == '0);
    end

    // Assemble the flag vector.
    always_comb begin
        cc.n = value[DATA_W-1];
        cc.z = (value == '0);
        cc.v = 1'b0;
        cc.c = |byte_zero;
    end

endmodule

// File: rtl/llsc_monitor.sv
// Module: llsc_monitor (top)
// Load-locked / store-conditional engine. Memory requests are issued in
// the request cycle. Results leave a two-stage pipeline two edges later.
// Assumes memory returns read data one cycle after the request, and that
// the snoop input carries only references made by other CPUs.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [3:0]        res_cc
);

    localparam int WORD_LSB = $clog2(DATA_W / BYTE_W);
    localparam logic [ADDR_W-1:0] WORD_MASK =
        {{(ADDR_W-WORD_LSB){1'b1}}, {WORD_LSB{1'b0}}};

    op_kind_e kind;
    logic     sc_pass;
    cc_t      load_cc;
    op_kind_e s1_kind;
    logic     s1_pass;

    llsc_decode u_decode (
        .op_valid (op_valid),
        .op_code  (op_code),
        .kind     (kind)
    );

    llsc_resv #(
        .ADDR_W   (ADDR_W),
        .WORD_LSB (WORD_LSB)
    ) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .ll_fire     (kind == KIND_LL),
        .sc_fire     (kind == KIND_SC),
        .op_addr     (op_addr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .sc_pass     (sc_pass)
    );

    llsc_ccgen #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_ccgen (
        .value (mem_rdata),
        .cc    (load_cc)
    );

    // Drive the memory port in the request cycle.
    always_comb begin
        mem_req   = (kind == KIND_LL) || sc_pass;
        mem_we    = sc_pass;
        mem_addr  = op_addr & WORD_MASK;
        mem_wdata = op_data;
    end

    // Stage 1: hold the kind and the store outcome while memory answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_kind <= KIND_NONE;
            s1_pass <= 1'b0;
        end else begin
            s1_kind <= kind;
            s1_pass <= sc_pass;
        end
    end

    // Stage 2: form the result word and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_cc    <= '0;
        end else begin
            res_valid <= (s1_kind != KIND_NONE);
            if (s1_kind == KIND_LL) begin
                res_data <= mem_rdata;
                res_cc   <= load_cc;
            end else begin
                res_data <= '0;
                res_cc   <= {1'b0, 1'b0, !s1_pass, 1'b0};
            end
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
// Module: llsc_monitor_chk
// Port-level temporal checks of the reservation monitor, bound to it.
module llsc_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [ADDR_W-1:0] op_addr,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              res_valid,
    input logic [3:0]        res_cc
);

    localparam int WORD_LSB = $clog2(DATA_W / BYTE_W);
    localparam logic [ADDR_W-1:0] WORD_MASK =
        {{(ADDR_W-WORD_LSB){1'b1}}, {WORD_LSB{1'b0}}};

    logic is_ll, is_sc, is_none, snoop_same;
    assign is_ll      = op_valid && (op_code == 4'b1001);
    assign is_sc      = op_valid && (op_code == 4'b1000);
    assign is_none    = !is_ll && !is_sc;
    assign snoop_same = snoop_valid &&
                        ((snoop_addr & WORD_MASK) == (op_addr & WORD_MASK));

    // R1
    nonop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_none |-> !mem_req);

    // R1
    nonop_noresult_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_none |=> ##1 !res_valid);

    // R2
    ll_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ll |-> (mem_req && !mem_we && ((mem_addr & ~WORD_MASK) == '0)));

    // R3
    ll_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ll |=> ##1 (res_valid && !res_cc[1]));

    // R5
    we_needs_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (is_sc && mem_req));

    // R5
    sc_ok_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ##1 (res_valid && res_cc == 4'b0000));

    // R6
    sc_fail_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && !mem_we) |=> ##1 (res_valid && res_cc == 4'b0010));

    // R9
    sc_snoop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && snoop_same) |-> !mem_we);

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_addr     (op_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .res_valid   (res_valid),
    .res_cc      (res_cc)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
// Directed bench for llsc_monitor: one task per scenario.
module llsc_monitor_tb;

    localparam logic [3:0] LL  = 4'b1001;
    localparam logic [3:0] SC  = 4'b1000;
    localparam logic [3:0] OTH = 4'b1010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic [3:0]  res_cc;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [16];
    logic        pl_we = 1'b0;
    logic [3:0]  pl_idx = '0;
    logic [31:0] pl_data = '0;

    logic        got_req, got_we, got_valid;
    logic [31:0] got_addr, got_data;
    logic [3:0]  got_cc;

    always #4 clk = ~clk;

    llsc_monitor u_dut (
        .clk (clk), .rst_n (rst_n),
        .op_valid (op_valid), .op_code (op_code),
        .op_addr (op_addr), .op_data (op_data),
        .mem_req (mem_req), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .snoop_valid (snoop_valid), .snoop_addr (snoop_addr),
        .res_valid (res_valid), .res_data (res_data), .res_cc (res_cc)
    );

    // Word memory with one-cycle read latency, plus a preload path.
    always @(posedge clk) begin
        if (pl_we) mem[pl_idx] <= pl_data;
        else if (mem_req) begin
            if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[5:2]];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk); pl_we = 1'b1; pl_idx = idx; pl_data = d;
        @(negedge clk); pl_we = 1'b0;
    endtask

    // Issue one request, optionally with a same-cycle snoop; capture results.
    task automatic issue(input logic [3:0] code, input logic [31:0] a, input logic [31:0] d,
                         input logic sv, input logic [31:0] sa);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = a; op_data = d;
        snoop_valid = sv; snoop_addr = sa;
        #1;
        got_req = mem_req; got_we = mem_we; got_addr = mem_addr;
        @(negedge clk);
        op_valid = 1'b0; snoop_valid = 1'b0;
        @(negedge clk);
        got_valid = res_valid; got_data = res_data; got_cc = res_cc;
    endtask

    task automatic snoop_pulse(input logic [31:0] sa);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = sa;
        @(negedge clk); snoop_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 res_valid after reset", {31'b0, res_valid}, 32'd0);
        issue(SC, 32'h10, 32'h1111_1111, 1'b0, 32'h0);
        check("R11 early store no write", {31'b0, got_we}, 32'd0);
        check("R11 early store cc", {28'b0, got_cc}, 32'h2);
        check("R6 memory kept", mem[4], 32'hA5A5_A5A5);
    endtask

    task automatic t_ll_basic;
        issue(LL, 32'h12, 32'h0, 1'b0, 32'h0);
        check("R2 read request", {30'b0, got_req, got_we}, 32'h2);
        check("R2 aligned address", got_addr, 32'h10);
        check("R2 result valid", {31'b0, got_valid}, 32'd1);
        check("R2 data", got_data, 32'hA5A5_A5A5);
        check("R3 negative flags", {28'b0, got_cc}, 32'h8);
    endtask

    task automatic t_ll_flags;
        issue(LL, 32'h14, 32'h0, 1'b0, 32'h0);
        check("R3 zero word flags", {28'b0, got_cc}, 32'h5);
        issue(LL, 32'h18, 32'h0, 1'b0, 32'h0);
        check("R3 zero byte flags", {28'b0, got_cc}, 32'h1);
    endtask

    task automatic t_sc_success;
        issue(LL, 32'h20, 32'h0, 1'b0, 32'h0);
        issue(SC, 32'h20, 32'hCAFE_0001, 1'b0, 32'h0);
        check("R5 write strobe", {30'b0, got_req, got_we}, 32'h3);
        check("R5 cc", {28'b0, got_cc}, 32'h0);
        check("R5 memory", mem[8], 32'hCAFE_0001);
        issue(SC, 32'h20, 32'hDEAD_0002, 1'b0, 32'h0);
        check("R7 second store fails", {28'b0, got_cc}, 32'h2);
        check("R7 memory kept", mem[8], 32'hCAFE_0001);
    endtask

    task automatic t_other_addr;
        issue(LL, 32'h20, 32'h0, 1'b0, 32'h0);
        issue(SC, 32'h24, 32'h0BAD_0003, 1'b0, 32'h0);
        check("R6 wrong word cc", {28'b0, got_cc}, 32'h2);
        check("R6 wrong word no write", mem[9], 32'h0000_0909);
    endtask

    task automatic t_replace;
        issue(LL, 32'h20, 32'h0, 1'b0, 32'h0);
        issue(LL, 32'h28, 32'h0, 1'b0, 32'h0);
        issue(SC, 32'h20, 32'h0BAD_0004, 1'b0, 32'h0);
        check("R4 replaced lock fails", {28'b0, got_cc}, 32'h2);
        issue(LL, 32'h20, 32'h0, 1'b0, 32'h0);
        issue(LL, 32'h28, 32'h0, 1'b0, 32'h0);
        issue(SC, 32'h28, 32'h1234_0005, 1'b0, 32'h0);
        check("R4 newest lock succeeds", {28'b0, got_cc}, 32'h0);
        check("R4 memory", mem[10], 32'h1234_0005);
    endtask

    task automatic t_snoop;
        issue(LL, 32'h30, 32'h0, 1'b0, 32'h0);
        snoop_pulse(32'h33);
        issue(SC, 32'h30, 32'h0BAD_0006, 1'b0, 32'h0);
        check("R8 snoop in word cancels", {28'b0, got_cc}, 32'h2);
        issue(LL, 32'h30, 32'h0, 1'b0, 32'h0);
        snoop_pulse(32'h34);
        issue(SC, 32'h30, 32'h5678_0007, 1'b0, 32'h0);
        check("R8 other word keeps", {28'b0, got_cc}, 32'h0);
        check("R8 memory", mem[12], 32'h5678_0007);
    endtask

    task automatic t_same_cycle;
        issue(LL, 32'h30, 32'h0, 1'b0, 32'h0);
        issue(SC, 32'h30, 32'h0BAD_0008, 1'b1, 32'h31);
        check("R9 snoop beats store", {31'b0, got_we}, 32'd0);
        check("R9 cc", {28'b0, got_cc}, 32'h2);
        issue(LL, 32'h38, 32'h0, 1'b1, 32'h38);
        issue(SC, 32'h38, 32'h0BAD_0009, 1'b0, 32'h0);
        check("R10 lock not opened", {28'b0, got_cc}, 32'h2);
        check("R10 memory kept", mem[14], 32'h0000_0E0E);
    endtask

    task automatic t_nonop;
        issue(LL, 32'h3C, 32'h0, 1'b0, 32'h0);
        issue(OTH, 32'h3C, 32'h0, 1'b0, 32'h0);
        check("R1 other code no access", {31'b0, got_req}, 32'd0);
        check("R1 other code no result", {31'b0, got_valid}, 32'd0);
        @(negedge clk);
        op_code = LL; op_addr = 32'h10; op_valid = 1'b0;
        #1;
        check("R1 idle no access", {31'b0, mem_req}, 32'd0);
        @(negedge clk); @(negedge clk);
        check("R1 idle no result", {31'b0, res_valid}, 32'd0);
        issue(SC, 32'h3C, 32'h7777_000A, 1'b0, 32'h0);
        check("R1 reservation untouched", {28'b0, got_cc}, 32'h0);
    endtask

    task automatic t_retry;
        issue(LL, 32'h24, 32'h0, 1'b0, 32'h0);
        snoop_pulse(32'h24);
        issue(SC, 32'h24, 32'h0BAD_000B, 1'b0, 32'h0);
        check("R12 first try fails", {28'b0, got_cc}, 32'h2);
        issue(LL, 32'h24, 32'h0, 1'b0, 32'h0);
        check("R12 reload data", got_data, 32'h0000_0909);
        issue(SC, 32'h24, 32'h0000_090A, 1'b0, 32'h0);
        check("R12 retry succeeds", {28'b0, got_cc}, 32'h0);
        check("R12 memory", mem[9], 32'h0000_090A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        preload(4'd4, 32'hA5A5_A5A5);
        preload(4'd5, 32'h0);
        preload(4'd6, 32'h1200_3456);
        preload(4'd9, 32'h0000_0909);
        preload(4'd14, 32'h0000_0E0E);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        preload(4'd4, 32'h80FF_1234);
        issue(LL, 32'h12, 32'h0, 1'b0, 32'h0);
        check("R3 sign flags", {28'b0, got_cc}, 32'h8);
        check("R2 data updated", got_data, 32'h80FF_1234);
        preload(4'd4, 32'hA5A5_A5A5);
        t_ll_basic();
        t_ll_flags();
        t_sc_success();
        t_other_addr();
        t_replace();
        t_snoop();
        t_same_cycle();
        t_nonop();
        t_retry();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule